// File: doc/BRIEF.md
# Compare Flag Generator

This block compares two operands by forming the difference of a destination operand minus a source operand. It never writes that difference anywhere. Both operand inputs are only read. From the subtraction it derives six status flags: carry/borrow, parity, nibble borrow, zero, sign and overflow. These flags let a following stage decide both the signed and the unsigned ordering of the two values.

A one-cycle start strobe launches a comparison. On the next clock edge the flags appear at registered outputs, together with a single-cycle valid pulse that a flag register can take as its write-back enable. The flags then hold their value until the next comparison.

A byte mode compares only the low eight bits of each operand. In that mode carry, sign, overflow and zero are taken at the byte boundary instead of the word boundary.

Top module: `cmp_flag_gen`

## Requirements
- R1: While reset is asserted, valid_o and all six flag outputs are 0.
- R2: valid_o is 1 in the cycle after a cycle in which start_i is 1 and 0 otherwise. The flags presented with that pulse belong to the operands and mode sampled together with start_i.
- R3: In a cycle after one in which start_i was 0, all six flag outputs keep their previous values.
- R4: zf_o is 1 exactly when the compared operand bits are equal: bits 15:0 in word mode, bits 7:0 in byte mode.
- R5: cf_o is 1 exactly when the subtraction borrows out of its top bit, that is, when D is below S as unsigned numbers.
- R6: sf_o equals the top bit of the difference (bit 15 in word mode).
- R7: of_o is 1 when the operand signs differ and the sign of the difference differs from the sign of D.
- R8: af_o is 1 when D[3:0] is below S[3:0] as unsigned numbers, that is, when the low nibble borrows out of bit 3.
- R9: pf_o is 1 when bits 7:0 of the difference hold an even number of ones, in both modes.
- R10: With byte_mode_i = 1, operand bits 15:8 have no effect. cf_o, sf_o and of_o are then taken at bit 7, and zf_o covers bits 7:0 only.
- R11: In word mode with zf_o = 0, sf_o XOR of_o is 1 exactly when D is less than S as signed two's-complement numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a comparison of the current operands |
| byte_mode_i | input | 1 | 1 selects 8-bit comparison, 0 selects 16-bit |
| opd_d_i | input | 16 | Destination operand D (minuend) |
| opd_s_i | input | 16 | Source operand S (subtrahend) |
| valid_o | output | 1 | One-cycle pulse marking fresh flags |
| cf_o | output | 1 | Borrow out of the top bit |
| pf_o | output | 1 | Even parity of difference bits 7:0 |
| af_o | output | 1 | Borrow out of bit 3 |
| zf_o | output | 1 | Operands equal |
| sf_o | output | 1 | Sign of the difference |
| of_o | output | 1 | Signed overflow of the subtraction |

## Verification
The temporal properties assume that operands and mode are driven to known values whenever start_i is high. They also assume that start_i is low while reset is asserted. Their $past references then always land on sampled, defined operands. The bench drives every input to zero from time zero and holds start_i low through reset. After that it changes inputs only on the falling edge, so each strobe pairs with stable operands. The stimulus mixes back-to-back strobes, idle gaps, mode changes between consecutive strobes, and byte-mode operands whose upper bytes differ. This way hold behaviour and the ignored upper bits are both exercised.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } cmp_flags_t;

    typedef struct packed {
        logic       valid;
        cmp_flags_t flags;
    } cmp_state_t;

    localparam cmp_state_t CMP_STATE_RESET = '0;

endpackage

// File: rtl/cmp_sub_slice.sv
module cmp_sub_slice #(
    parameter int W = 16
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    output logic [W-1:0] diff_o,
    output logic         borrow_o,
    output logic         ovf_o,
    output logic         zero_o
);
    localparam int TOP = W - 1;

    logic [W:0] wide;

    always_comb begin
        wide     = {1'b0, lhs_i} - {1'b0, rhs_i};
        diff_o   = wide[TOP:0];
        borrow_o = wide[W];
        ovf_o    = (lhs_i[TOP] ^ rhs_i[TOP]) & (wide[TOP] ^ lhs_i[TOP]);
        zero_o   = ~|wide[TOP:0];
    end

    // R5
    always_comb begin
        slice_borrow_chk: assert (borrow_o == (lhs_i < rhs_i));
    end

endmodule

// File: rtl/cmp_parity.sv
module cmp_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] data_i,
    output logic         even_o
);
    logic [W:0] chain;

    assign chain[0] = 1'b1;

    for (genvar g = 0; g < W; g++) begin : g_par
        assign chain[g+1] = chain[g] ^ data_i[g];
    end

    assign even_o = chain[W];

endmodule

// File: rtl/cmp_flag_gen.sv
module cmp_flag_gen
    import cmp_flag_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              byte_mode_i,
    input  logic [WORD_W-1:0] opd_d_i,
    input  logic [WORD_W-1:0] opd_s_i,
    output logic              valid_o,
    output logic              cf_o,
    output logic              pf_o,
    output logic              af_o,
    output logic              zf_o,
    output logic              sf_o,
    output logic              of_o
);
    localparam int WORD_TOP = WORD_W - 1;
    localparam int BYTE_TOP = BYTE_W - 1;
    localparam int NIB_TOP  = NIB_W - 1;

    logic [WORD_W-1:0] w_diff;
    logic              w_borrow, w_ovf, w_zero;
    logic [BYTE_W-1:0] b_diff;
    logic              b_borrow, b_ovf, b_zero;
    logic [NIB_W-1:0]  n_diff;
    logic              n_borrow, n_ovf, n_zero;
    logic              low_even;

    cmp_sub_slice #(.W(WORD_W)) u_word (
        .lhs_i   (opd_d_i),
        .rhs_i   (opd_s_i),
        .diff_o  (w_diff),
        .borrow_o(w_borrow),
        .ovf_o   (w_ovf),
        .zero_o  (w_zero)
    );

    cmp_sub_slice #(.W(BYTE_W)) u_byte (
        .lhs_i   (opd_d_i[BYTE_TOP:0]),
        .rhs_i   (opd_s_i[BYTE_TOP:0]),
        .diff_o  (b_diff),
        .borrow_o(b_borrow),
        .ovf_o   (b_ovf),
        .zero_o  (b_zero)
    );

    cmp_sub_slice #(.W(NIB_W)) u_nib (
        .lhs_i   (opd_d_i[NIB_TOP:0]),
        .rhs_i   (opd_s_i[NIB_TOP:0]),
        .diff_o  (n_diff),
        .borrow_o(n_borrow),
        .ovf_o   (n_ovf),
        .zero_o  (n_zero)
    );

    cmp_parity #(.W(BYTE_W)) u_par (
        .data_i(b_diff),
        .even_o(low_even)
    );

    cmp_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = start_i;
        if (start_i) begin
            st_d.flags.af = n_borrow;
            st_d.flags.pf = low_even;
            if (byte_mode_i) begin
                st_d.flags.cf = b_borrow;
                st_d.flags.zf = b_zero;
                st_d.flags.sf = b_diff[BYTE_TOP];
                st_d.flags.of = b_ovf;
            end else begin
                st_d.flags.cf = w_borrow;
                st_d.flags.zf = w_zero;
                st_d.flags.sf = w_diff[WORD_TOP];
                st_d.flags.of = w_ovf;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= CMP_STATE_RESET;
        else         st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign cf_o    = st_q.flags.cf;
    assign pf_o    = st_q.flags.pf;
    assign af_o    = st_q.flags.af;
    assign zf_o    = st_q.flags.zf;
    assign sf_o    = st_q.flags.sf;
    assign of_o    = st_q.flags.of;

    // R1
    always_comb begin
        if (!rst_ni) reset_clear_chk: assert (st_q == CMP_STATE_RESET);
    end

    // R2
    valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> valid_o);

    // R2
    valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> !valid_o);

    // R3
    hold_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> $stable({cf_o, pf_o, af_o, zf_o, sf_o, of_o}));

    // R4
    zero_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !byte_mode_i |=> zf_o == ($past(opd_d_i) == $past(opd_s_i)));

    // R5
    borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !byte_mode_i |=> cf_o == ($past(opd_d_i) < $past(opd_s_i)));

    // R10
    byte_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && byte_mode_i |=>
            cf_o == ($past(opd_d_i[BYTE_TOP:0]) < $past(opd_s_i[BYTE_TOP:0])));

    // R11
    signed_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !byte_mode_i |=>
            zf_o || ((sf_o ^ of_o) == ($signed($past(opd_d_i)) < $signed($past(opd_s_i)))));

endmodule

// File: tb/cmp_flag_gen_bench.sv
`timescale 1ns/1ps
module cmp_flag_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        byte_mode = 1'b0;
    logic [15:0] opd_d = '0;
    logic [15:0] opd_s = '0;
    logic        valid, cf, pf, af, zf, sf, of;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cmp_flag_gen u_cmp_flag_gen (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .byte_mode_i(byte_mode),
        .opd_d_i    (opd_d),
        .opd_s_i    (opd_s),
        .valid_o    (valid),
        .cf_o       (cf),
        .pf_o       (pf),
        .af_o       (af),
        .zf_o       (zf),
        .sf_o       (sf),
        .of_o       (of)
    );

    // reference model state
    bit e_valid, e_cf, e_pf, e_af, e_zf, e_sf, e_of, e_byte, e_slt;
    int m_mask, m_top, m_a, m_b, m_diff, m_sa, m_sb, m_sd, m_max;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {e_valid, e_cf, e_pf, e_af, e_zf, e_sf, e_of, e_byte, e_slt} = '0;
        end else begin
            e_valid = start;
            if (start) begin
                e_byte = byte_mode;
                m_mask = byte_mode ? 'hFF : 'hFFFF;
                m_top  = byte_mode ? 7 : 15;
                m_max  = m_mask >> 1;
                m_a    = int'(opd_d) & m_mask;
                m_b    = int'(opd_s) & m_mask;
                m_diff = (m_a - m_b) & m_mask;
                m_sa   = (m_a > m_max) ? m_a - (m_mask + 1) : m_a;
                m_sb   = (m_b > m_max) ? m_b - (m_mask + 1) : m_b;
                m_sd   = m_sa - m_sb;
                e_cf   = m_a < m_b;
                e_zf   = m_a == m_b;
                e_sf   = ((m_diff >> m_top) & 1) == 1;
                e_of   = (m_sd > m_max) || (m_sd < -(m_max + 1));
                e_af   = (m_a & 15) < (m_b & 15);
                e_pf   = ($countones(m_diff & 'hFF) % 2) == 0;
                e_slt  = m_sa < m_sb;
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        string t_cf, t_pf, t_af, t_zf, t_sf, t_of;
        if (!rst_n) begin
            t_cf = "R1"; t_pf = "R1"; t_af = "R1"; t_zf = "R1"; t_sf = "R1"; t_of = "R1";
            chk("R1", "valid", int'(valid), 0);
        end else begin
            chk("R2", "valid", int'(valid), int'(e_valid));
            if (!e_valid) begin
                t_cf = "R3"; t_pf = "R3"; t_af = "R3"; t_zf = "R3"; t_sf = "R3"; t_of = "R3";
            end else if (e_byte) begin
                t_cf = "R10"; t_pf = "R9"; t_af = "R8"; t_zf = "R10"; t_sf = "R10"; t_of = "R10";
            end else begin
                t_cf = "R5"; t_pf = "R9"; t_af = "R8"; t_zf = "R4"; t_sf = "R6"; t_of = "R7";
            end
        end
        chk(t_cf, "cf", int'(cf), int'(e_cf));
        chk(t_pf, "pf", int'(pf), int'(e_pf));
        chk(t_af, "af", int'(af), int'(e_af));
        chk(t_zf, "zf", int'(zf), int'(e_zf));
        chk(t_sf, "sf", int'(sf), int'(e_sf));
        chk(t_of, "of", int'(of), int'(e_of));
        if (rst_n && e_valid && !e_byte && !zf)
            chk("R11", "sf^of", int'(sf ^ of), int'(e_slt));
    endtask

    task automatic step(input bit st, input bit bm, input logic [15:0] d, input logic [15:0] s);
        @(negedge clk);
        check_all();
        start = st; byte_mode = bm; opd_d = d; opd_s = s;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_all();
        end
        rst_n = 1'b1;
        // directed: R4 R5 R6 R7 R8 R9 corner values
        step(1, 0, 16'h1234, 16'hABCD);
        step(0, 0, 16'hFFFF, 16'h0000);
        step(0, 0, 16'h0000, 16'h0001);
        step(1, 0, 16'h5A5A, 16'h5A5A);
        step(1, 0, 16'h8000, 16'h0001);
        step(1, 0, 16'h7FFF, 16'hFFFF);
        step(1, 0, 16'h0000, 16'h0000);
        step(1, 0, 16'h0010, 16'h0001);
        // byte mode, upper bits differ (R10)
        step(1, 1, 16'hAB12, 16'h3412);
        step(1, 1, 16'h0080, 16'hFF01);
        step(1, 1, 16'h127F, 16'h00FF);
        step(0, 1, 16'h0000, 16'hFFFF);
        step(1, 0, 16'h0012, 16'hFF12);
        step(0, 0, 16'h0000, 16'h0000);
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 10) < 6, $urandom % 2,
                 (i % 7 == 0) ? 16'($urandom % 4) : 16'($urandom),
                 (i % 5 == 0) ? 16'($urandom % 4) : 16'($urandom));
        end
        step(0, 0, 16'h0000, 16'h0000);
        step(0, 0, 16'h0000, 16'h0000);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule